// File: doc/BRIEF.md
# Passive-Parallel Configuration Sequencer

This block runs one complete configuration of an attached programmable device over a passive-parallel port. A single `start` pulse launches the run. The block first checks the mode-select pins. It then waits until no other agent is pulling the configuration lines, takes over the configuration and reset-request overrides, and selects the device through its chip-enable. It pulses the reset request against the status handshake and verifies that the done pin reads low and is enabled. After that it opens the configuration control and data path.

Moving the configuration data is left to an external streamer, which reports the end of the data on `data_done_i`. The block then polls for the done pin and asks the clock generator for a fixed number of extra configuration clocks. It waits for the device to report user mode, withdraws its overrides and the chip-enable, and makes a final check of the status pins.

Every wait is bounded by a cycle count set by a parameter. Each failure ends the run with its own error code. While the block is idle, and after any failure, it leaves the pins in the released state.

Top module: `pp_cfg_seq`

## Requirements
- R1: When a run starts, mode-select bits above bit 0 must all be zero; otherwise the run ends with error code 1 two clock edges after `start_i` is taken, without the overrides or `nce_o` ever becoming active.
- R2: Before it takes any control, the block waits until both `ncfg_pin_i` and `nstat_pin_i` read high; if they do not within WAIT_LIMIT cycles, the run ends with error code 2 (timeout).
- R3: Both override-enable outputs (`cfg_ovr_n_o`, `ncfg_ovr_n_o`, active low) go low at least one cycle before `nce_o` falls, and `nce_o` is never low while either override output is high.
- R4: The reset pulse holds `ncfg_drv_o` low until `nstat_pin_i` reads low, then drives it high and waits for `nstat_pin_i` high; each of these waits times out after WAIT_LIMIT cycles with error code 2.
- R5: After the reset pulse, `cdone_pin_i` must read 0 and `cdone_oe_i` must read 1, or the run ends with error code 3 (pin state); only when both hold does `cfg_en_o` rise.
- R6: After `data_done_i`, the block polls for `cdone_pin_i` high; if `nstat_pin_i` reads low before that, error code 4 results, and POLL_LIMIT cycles without the done pin give error code 2.
- R7: Once the done pin is seen, `dclk_req_o` pulses for exactly one cycle with `dclk_cnt_o` equal to DCLK_EXTRA (15 by default); user mode is then awaited for at most WAIT_LIMIT cycles, else error code 2.
- R8: After user mode, `cfg_en_o` falls, both override outputs return high and `nce_o` returns high; then `usermode_i`, `cdone_pin_i` and `nstat_pin_i` must all be high for `ok_o`, else error code 3.
- R9: `busy_o` is high from the cycle after `start_i` is taken until the run ends; `ok_o` and `err_o` then hold until the next accepted start, which clears both.
- R10: In every terminal state and in idle, the drives are released: `nce_o`=1, `ncfg_drv_o`=1, both override outputs 1, `cfg_en_o`=0, `dclk_req_o`=0.
- R11: A `start_i` pulse while `busy_o` is high has no effect on the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a configuration run (taken when not busy) |
| data_done_i | input | 1 | External streamer has sent all configuration data |
| msel_i | input | MSEL_W | Mode-select pin levels |
| ncfg_pin_i | input | 1 | Observed level of the reset-request pin |
| nstat_pin_i | input | 1 | Observed level of the status pin |
| cdone_pin_i | input | 1 | Observed level of the done pin |
| cdone_oe_i | input | 1 | Output enable of the done pin |
| usermode_i | input | 1 | Device reports user mode |
| ncfg_drv_o | output | 1 | Reset-request drive value (0 = request reset) |
| nce_o | output | 1 | Chip-enable drive, active low |
| cfg_ovr_n_o | output | 1 | Configuration-line override, active low |
| ncfg_ovr_n_o | output | 1 | Reset-request override, active low |
| cfg_en_o | output | 1 | Configuration control and data path enable |
| dclk_req_o | output | 1 | One-cycle request for extra configuration clocks |
| dclk_cnt_o | output | $clog2(DCLK_EXTRA+1) | Number of extra clocks requested (zero when no request) |
| busy_o | output | 1 | Run in progress |
| ok_o | output | 1 | Last run finished successfully |
| err_o | output | 3 | Error code of the last run: 0 none, 1 mode, 2 timeout, 3 pin state, 4 status low |

## Verification
The assertions take it that every pin input is synchronous to `clk` and steady between rising edges. They also expect the device side to behave causally: the status pin follows the reset-request pin only after a delay, and the done pin rises only after the data path is enabled. The bench meets this with a behavioural device model that updates every input on the falling edge. The model has random delays, and a fault can be switched on for each run: stuck status, a long external hold, a wrong done-pin enable, status dropping during the poll, a missing done pin, late user mode or a done pin lost at the final check.

// File: rtl/pp_cfg_seq.sv
module pp_cfg_seq #(
  parameter int MSEL_W     = 3,
  parameter int WAIT_LIMIT = 64,
  parameter int POLL_LIMIT = 128,
  parameter int DCLK_EXTRA = 15,
  localparam int DCW       = $clog2(DCLK_EXTRA + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              data_done_i,
  input  logic [MSEL_W-1:0] msel_i,
  input  logic              ncfg_pin_i,
  input  logic              nstat_pin_i,
  input  logic              cdone_pin_i,
  input  logic              cdone_oe_i,
  input  logic              usermode_i,
  output logic              ncfg_drv_o,
  output logic              nce_o,
  output logic              cfg_ovr_n_o,
  output logic              ncfg_ovr_n_o,
  output logic              cfg_en_o,
  output logic              dclk_req_o,
  output logic [DCW-1:0]    dclk_cnt_o,
  output logic              busy_o,
  output logic              ok_o,
  output logic [2:0]        err_o
);

  localparam int MAXL  = (WAIT_LIMIT > POLL_LIMIT) ? WAIT_LIMIT : POLL_LIMIT;
  localparam int CNT_W = $clog2(MAXL + 1);

  localparam logic [2:0] E_NONE = 3'd0;
  localparam logic [2:0] E_MODE = 3'd1;
  localparam logic [2:0] E_TMO  = 3'd2;
  localparam logic [2:0] E_PIN  = 3'd3;
  localparam logic [2:0] E_NST  = 3'd4;

  typedef enum logic [4:0] {
    S_IDLE, S_MODE, S_FREE1, S_RELS, S_OVRD, S_FREE2, S_PLO, S_PHI,
    S_CDCK, S_STRM, S_POLL, S_DCLK, S_UMW, S_FIN, S_FCHK, S_DONE, S_FAIL
  } st_t;

  st_t              state, nxt;
  logic [2:0]       fcode;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  logic             expired;
  logic             ovr_on;
  logic             terminal;

  assign lim      = (state == S_POLL) ? CNT_W'(POLL_LIMIT - 1) : CNT_W'(WAIT_LIMIT - 1);
  assign expired  = (cnt == lim);
  assign terminal = (state == S_IDLE) || (state == S_DONE) || (state == S_FAIL);

  always_comb begin
    nxt   = state;
    fcode = E_NONE;
    case (state)
      S_IDLE, S_DONE, S_FAIL:
        if (start_i) nxt = S_MODE;
      S_MODE:
        if (|(msel_i >> 1)) begin nxt = S_FAIL; fcode = E_MODE; end
        else nxt = S_FREE1;
      S_FREE1:
        if (ncfg_pin_i && nstat_pin_i) nxt = S_RELS;
        else if (expired) begin nxt = S_FAIL; fcode = E_TMO; end
      S_RELS: nxt = S_OVRD;
      S_OVRD: nxt = S_FREE2;
      S_FREE2:
        if (ncfg_pin_i && nstat_pin_i) nxt = S_PLO;
        else if (expired) begin nxt = S_FAIL; fcode = E_TMO; end
      S_PLO:
        if (!nstat_pin_i) nxt = S_PHI;
        else if (expired) begin nxt = S_FAIL; fcode = E_TMO; end
      S_PHI:
        if (nstat_pin_i) nxt = S_CDCK;
        else if (expired) begin nxt = S_FAIL; fcode = E_TMO; end
      S_CDCK:
        if (!cdone_pin_i && cdone_oe_i) nxt = S_STRM;
        else begin nxt = S_FAIL; fcode = E_PIN; end
      S_STRM:
        if (data_done_i) nxt = S_POLL;
      S_POLL:
        if (cdone_pin_i) nxt = S_DCLK;
        else if (!nstat_pin_i) begin nxt = S_FAIL; fcode = E_NST; end
        else if (expired) begin nxt = S_FAIL; fcode = E_TMO; end
      S_DCLK: nxt = S_UMW;
      S_UMW:
        if (usermode_i) nxt = S_FIN;
        else if (expired) begin nxt = S_FAIL; fcode = E_TMO; end
      S_FIN: nxt = S_FCHK;
      S_FCHK:
        if (usermode_i && cdone_pin_i && nstat_pin_i) nxt = S_DONE;
        else begin nxt = S_FAIL; fcode = E_PIN; end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
      err_o <= E_NONE;
    end else begin
      state <= nxt;
      cnt   <= (nxt != state) ? '0 : cnt + 1'b1;
      if (terminal && start_i)
        err_o <= E_NONE;
      else if (nxt == S_FAIL && state != S_FAIL)
        err_o <= fcode;
    end
  end

  assign ovr_on = state inside {S_OVRD, S_FREE2, S_PLO, S_PHI, S_CDCK,
                                S_STRM, S_POLL, S_DCLK, S_UMW};
  assign cfg_ovr_n_o  = !ovr_on;
  assign ncfg_ovr_n_o = !ovr_on;
  assign nce_o        = !(state inside {S_FREE2, S_PLO, S_PHI, S_CDCK,
                                        S_STRM, S_POLL, S_DCLK, S_UMW});
  assign ncfg_drv_o   = (state != S_PLO);
  assign cfg_en_o     = state inside {S_STRM, S_POLL, S_DCLK, S_UMW};
  assign dclk_req_o   = (state == S_DCLK);
  assign dclk_cnt_o   = dclk_req_o ? DCW'(DCLK_EXTRA) : '0;
  assign busy_o       = !terminal;
  assign ok_o         = (state == S_DONE);

  // R1
  mode_err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o == E_MODE) |-> (nce_o && cfg_ovr_n_o && ncfg_ovr_n_o));
  // R2
  takeover_pins_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_ovr_n_o) |-> $past(ncfg_pin_i && nstat_pin_i, 2));
  // R3
  select_after_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nce_o) |-> ($past(!cfg_ovr_n_o) && $past(!ncfg_ovr_n_o)));
  // R4
  reset_release_handshake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ncfg_drv_o) && busy_o) |-> $past(!nstat_pin_i));
  // R5
  enable_after_cdone_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_en_o) |-> $past(!cdone_pin_i && cdone_oe_i));
  // R6
  dclk_after_cdone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dclk_req_o) |-> $past(cdone_pin_i));
  // R7
  dclk_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dclk_req_o |=> !dclk_req_o);
  // R8
  ok_final_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ok_o) |-> $past(usermode_i && cdone_pin_i && nstat_pin_i));
  // R9
  end_has_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (ok_o != (err_o != E_NONE)));
  // R10
  fail_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o != E_NONE) |-> (nce_o && ncfg_drv_o && cfg_ovr_n_o && ncfg_ovr_n_o && !cfg_en_o));

endmodule

// File: tb/test_pp_cfg_seq.sv
module test_pp_cfg_seq;
  localparam int WL = 64;
  localparam int PL = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic data_done = 1'b0;
  logic [2:0] msel = 3'd0;
  logic ncfg_pin = 1'b1, nstat_pin = 1'b1, cdone_pin = 1'b0, cdone_oe = 1'b1, um = 1'b0;
  logic ncfg_drv, nce, cfg_ovr_n, ncfg_ovr_n, cfg_en, dclk_req, busy, ok;
  logic [3:0] dclk_cnt;
  logic [2:0] err;

  always #2.5 clk = ~clk;

  pp_cfg_seq #(.MSEL_W(3), .WAIT_LIMIT(WL), .POLL_LIMIT(PL), .DCLK_EXTRA(15)) i_pp_cfg_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .data_done_i(data_done), .msel_i(msel),
    .ncfg_pin_i(ncfg_pin), .nstat_pin_i(nstat_pin), .cdone_pin_i(cdone_pin),
    .cdone_oe_i(cdone_oe), .usermode_i(um), .ncfg_drv_o(ncfg_drv), .nce_o(nce),
    .cfg_ovr_n_o(cfg_ovr_n), .ncfg_ovr_n_o(ncfg_ovr_n), .cfg_en_o(cfg_en),
    .dclk_req_o(dclk_req), .dclk_cnt_o(dclk_cnt), .busy_o(busy), .ok_o(ok), .err_o(err));

  int n_checks = 0, n_fail = 0;
  // device model knobs
  int hold_cnt = 0, nd = 1, dd_dly = 0, cd_dly = 8, um_dly = 0;
  bit stuck = 0, badoe = 0, drop = 0, cdnever = 0, finbad = 0;
  // device model state
  bit trk = 1, dropped = 0, dd_given = 0;
  int ncnt = 0, ddc = 0, cdc = 0, dpc = 0, umc = 0, req_seen = 0, req_val = 0, viol = 0;

  task automatic check(input bit cond, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_code(input logic [2:0] m, input bit stk, input bit hlong, input bit slow,
                                  input bit boe, input bit drp, input bit cdn, input bit uml, input bit fb);
    if (m[2:1] != 2'b00) return 1;
    if (stk || hlong || slow) return 2;
    if (boe) return 3;
    if (drp) return 4;
    if (cdn || uml) return 2;
    if (fb) return 3;
    return 0;
  endfunction

  function automatic bit released();
    return nce && ncfg_drv && cfg_ovr_n && ncfg_ovr_n && !cfg_en && !dclk_req;
  endfunction

  // behavioural device, updated away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      if (hold_cnt > 0) hold_cnt--;
      ncfg_pin = ncfg_drv && (hold_cnt == 0);
      if (trk != ncfg_pin) begin
        if (ncnt + 1 >= nd) begin trk = ncfg_pin; ncnt = 0; end
        else ncnt++;
      end else ncnt = 0;
      data_done = 1'b0;
      if (cfg_en && !dd_given) begin
        if (ddc >= dd_dly) begin data_done = 1'b1; dd_given = 1; end
        else ddc++;
      end
      if (dd_given && cfg_en && !cdnever && !cdone_pin) begin
        if (cdc >= cd_dly) cdone_pin = 1'b1; else cdc++;
      end
      if (drop && dd_given && cfg_en && !dropped) begin
        if (dpc >= 2) dropped = 1; else dpc++;
      end
      nstat_pin = trk && !stuck && !dropped;
      if (dclk_req) begin req_seen++; req_val = dclk_cnt; end
      if (req_seen > 0 && !um) begin
        if (umc >= um_dly) um = 1'b1; else umc++;
      end
      if (finbad && um && !cfg_en) cdone_pin = 1'b0;
      if (!nce && (cfg_ovr_n || ncfg_ovr_n)) viol++;
    end
  end

  task automatic prep();
    stuck = 0; badoe = 0; drop = 0; cdnever = 0; finbad = 0;
    dropped = 0; dd_given = 0; ddc = 0; cdc = 0; dpc = 0; umc = 0;
    req_seen = 0; req_val = 0; viol = 0; um = 1'b0; cdone_pin = 1'b0;
    hold_cnt = 0; trk = 1; ncnt = 0;
  endtask

  task automatic run_case(input string tag, input int code, input bit mid);
    int n;
    bit mdone;
    logic [2:0] e0;
    logic o0;
    cdone_oe = !badoe;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    // R9: accepted start clears the verdict and raises busy
    check(busy && !ok && err == 3'd0, "R9", "busy after start", {busy, ok, err}, 5'b10000);
    n = 0; mdone = 0;
    while (busy && n < 3000) begin
      if (mid && cfg_en && !mdone) begin start = 1'b1; mdone = 1; end
      else start = 1'b0;
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    check(int'(err) == code && ok == (code == 0), tag, "result code", int'(err), code);
    // R10: released after the end
    check(released(), "R10", "drives released", {nce, ncfg_drv, cfg_ovr_n, ncfg_ovr_n, cfg_en, dclk_req}, 6'b111100);
    // R3
    check(viol == 0, "R3", "nce low without overrides", viol, 0);
    if (code == 0) begin
      // R7
      check(req_seen == 1 && req_val == 15, "R7", "dclk request count/value", req_seen * 100 + req_val, 115);
      // R8
      check(um && cdone_pin && ok, "R8", "final state ok", ok, 1);
    end
    e0 = err; o0 = ok;
    repeat (4) @(negedge clk);
    check(err == e0 && ok == o0 && !busy, "R9", "verdict held", {ok, err}, {o0, e0});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !ok && err == 3'd0 && released(), "R10", "reset state", {busy, ok, err}, 0);

    // R1: directed mode error timing
    prep(); msel = 3'd2;
    start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    check(busy && err == 3'd0, "R1", "first cycle busy", {busy, err}, 4'b1000);
    @(posedge clk); @(negedge clk);
    check(!busy && err == 3'd1, "R1", "mode error after two edges", int'(err), 1);
    check(nce && cfg_ovr_n && ncfg_ovr_n, "R1", "pins untouched", {nce, cfg_ovr_n}, 2'b11);
    msel = 3'd1;

    // directed corners
    prep(); nd = 3; dd_dly = 0; cd_dly = 0; um_dly = 0;
    run_case("R8", 0, 0);
    prep(); hold_cnt = 200; nd = 2;
    run_case("R2", 2, 0);
    prep(); stuck = 1;
    run_case("R2", 2, 0);
    prep(); nd = 80;
    run_case("R4", 2, 0);
    nd = 2;
    prep(); badoe = 1;
    run_case("R5", 3, 0);
    prep(); drop = 1; cd_dly = 10;
    run_case("R6", 4, 0);
    prep(); cdnever = 1;
    run_case("R6", 2, 0);
    prep(); um_dly = 200;
    run_case("R7", 2, 0);
    prep(); finbad = 1; um_dly = 3;
    run_case("R8", 3, 0);
    prep(); um_dly = 4; cd_dly = 6; dd_dly = 5;
    run_case("R11", 0, 1);

    // constrained random runs
    for (int k = 0; k < 40; k++) begin
      int kind;
      bit hl, sl, mid;
      string tag;
      prep();
      kind = int'($urandom % 11);
      hl = 0; sl = 0;
      msel = 3'($urandom % 2);
      hold_cnt = int'($urandom % 21);
      nd = 1 + int'($urandom % 12);
      dd_dly = int'($urandom % 21);
      cd_dly = 8 + int'($urandom % 23);
      um_dly = int'($urandom % 41);
      mid = ($urandom % 4) == 0;
      tag = "R8";
      case (kind)
        0: begin msel = 3'(2 + $urandom % 6); tag = "R1"; end
        1: begin stuck = 1; tag = "R2"; end
        2: begin hold_cnt = 200; hl = 1; tag = "R2"; end
        3: begin badoe = 1; tag = "R5"; end
        4: begin drop = 1; tag = "R6"; end
        5: begin cdnever = 1; tag = "R6"; end
        6: begin um_dly = 200; tag = "R7"; end
        7: begin finbad = 1; tag = "R8"; end
        10: begin hold_cnt = 0; nd = 80; sl = 1; tag = "R4"; end
        default: tag = mid ? "R11" : "R8";
      endcase
      run_case(tag, exp_code(msel, stuck, hl, sl, badoe, drop, cdnever, um_dly > WL, finbad), mid);
      nd = 2;
    end

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule